// File: doc/BRIEF.md
# Infrared Carrier Mark-Space Modulator

This block produces a single modulated transmit line for remote-control style infrared links. A modulation cycle is a mark phase followed by a space phase, both timed in ticks of a selectable clock divider. During mark the line carries a square-wave carrier, or is held high in baseband mode. During space the line is low. With the frequency-shift option, successive marks alternate between two carrier high/low count pairs. An extended-space option replaces the marks of later cycles with space.

Software programs the block through a byte-wide register port. The mark and space periods are 16-bit buffers written as separate high and low bytes. They take effect only when a cycle ends, so the next cycle can be staged while the current one runs. An end-of-cycle flag marks the start of a transmission and each completed cycle, and it can raise an interrupt. The flag clears after a status read followed by a write to the upper byte of either period buffer, or on a transfer-acknowledge strobe.

Register map (byte address: content): 0 control/status; 1 mark high byte; 2 mark low byte; 3 space high byte; 4 space low byte; 5 and 6 primary carrier high and low counts; 7 and 8 secondary carrier high and low counts. Control bits: 0 enable, 1 baseband, 2 frequency-shift, 3 extended space, 4 interrupt enable, 6:5 prescale code; bit 7 reads the end-of-cycle flag. Reads of address 0 return the control bits with the flag in bit 7. Other addresses read back their stored byte.

Top module: `irtx_modulator`

## Requirements
- R1: Prescale code p (control bits 6:5) makes one tick every 2^p clocks (codes 0..3 give 1, 2, 4, 8). A phase of N ticks lasts N*2^p clocks once the transmission is aligned to ticks.
- R2: With baseband set (control bit 1), mod_o is high for the mark count in ticks and then low for the space count in ticks. A count of 0 acts as 1.
- R3: With baseband clear, mod_o starts each mark high and follows a carrier that stays high for the high count and low for the low count, in ticks, repeating until the mark ends. mod_o is low during space.
- R4: With frequency-shift set (control bit 2), the first mark after a start uses the primary pair (addresses 5, 6). Later marks alternate between the secondary pair (addresses 7, 8) and the primary pair.
- R5: A write to a period buffer during a cycle does not change that cycle. The next cycle uses the new value.
- R6: When the block is idle and enable is set, the first mark begins one clock after the control write is captured, and the end-of-cycle flag sets.
- R7: The end-of-cycle flag sets at the end of every cycle that completes while enable is set.
- R8: The flag clears on a write to address 1 or 3 only when a read of address 0 came before it. The same write without a prior read leaves the flag set.
- R9: A one-clock pulse on dma_ack_i clears the flag.
- R10: irq_o is high exactly while the flag is set and the interrupt enable (control bit 4) is 1.
- R11: With extended space set (control bit 3), every cycle that starts after the setting is all space and mod_o stays low. Clearing it brings marks back.
- R12: Clearing enable lets the current cycle finish, then the block goes idle with mod_o low.
- R13: After reset, mod_o, irq_o and the status byte are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a read of address 0 arms flag clearing) |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| dma_ack_i | input | 1 | Transfer acknowledge; clears the end-of-cycle flag |
| mod_o | output | 1 | Modulated transmit output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit mark and space periods, 8-bit carrier counts and a 2-bit prescale select. With these values all four divide ratios, zero period counts and short one- to three-tick carrier counts can be reached within a few hundred clocks, and the 200-tick periods used for flag handling leave room for the read-then-write clearing sequence inside one phase. Pulse lengths are measured from the output line alone, and frequency-shift marks are told apart by how many carrier edges each burst contains.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_MARK_HI  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MARK_LO  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SPACE_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_SPACE_LO = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAR0_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CAR0_LO  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAR1_HI  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAR1_LO  = 4'd8;

  typedef enum logic [1:0] {PH_IDLE, PH_MARK, PH_SPACE} phase_e;

  typedef struct packed {
    logic [1:0] presc;
    logic       irq_en;
    logic       ext_space;
    logic       fsk;
    logic       baseband;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/irtx_prescaler.sv
module irtx_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask_w;

  always_comb mask_w = DIV_W'((1 << sel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + DIV_W'(1);
  end

  assign tick_o = (cnt_q & mask_w) == mask_w;
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int unsigned CAR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CAR_W-1:0] high_i,
  input  logic [CAR_W-1:0] low_i,
  output logic             lvl_o
);
  logic [CAR_W-1:0] cnt_q;
  logic [CAR_W-1:0] lim_w;
  logic [CAR_W-1:0] last_w;
  logic             lvl_q;

  always_comb begin
    lim_w  = lvl_q ? high_i : low_i;
    last_w = (lim_w == '0) ? '0 : lim_w - CAR_W'(1);
  end

  // idle: parked high so every mark opens with a full high half-period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (tick_i) begin
      if (cnt_q >= last_w) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
      end else begin
        cnt_q <= cnt_q + CAR_W'(1);
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer
  import irtx_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             ext_i,
  input  logic             fsk_i,
  input  logic [PER_W-1:0] mark_buf_i,
  input  logic [PER_W-1:0] space_buf_i,
  output phase_e           phase_o,
  output logic             pair_sel_o,
  output logic             evt_o
);
  phase_e           phase_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] space_q;
  logic             sel_q;
  logic             start_w;
  logic             end_w;

  function automatic logic [PER_W-1:0] first_cnt(input logic [PER_W-1:0] v);
    return (v == '0) ? '0 : v - PER_W'(1);
  endfunction

  assign start_w = (phase_q == PH_IDLE) && en_i;
  assign end_w   = tick_i && (phase_q == PH_SPACE) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      space_q <= '0;
      sel_q   <= 1'b0;
    end else if (start_w) begin
      space_q <= space_buf_i;
      sel_q   <= 1'b0;
      phase_q <= ext_i ? PH_SPACE : PH_MARK;
      cnt_q   <= ext_i ? first_cnt(space_buf_i) : first_cnt(mark_buf_i);
    end else if (tick_i && phase_q != PH_IDLE) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - PER_W'(1);
      end else if (phase_q == PH_MARK) begin
        phase_q <= PH_SPACE;
        cnt_q   <= first_cnt(space_q);
      end else if (en_i) begin
        // cycle boundary: buffered periods become active here only
        space_q <= space_buf_i;
        sel_q   <= fsk_i ? ~sel_q : 1'b0;
        phase_q <= ext_i ? PH_SPACE : PH_MARK;
        cnt_q   <= ext_i ? first_cnt(space_buf_i) : first_cnt(mark_buf_i);
      end else begin
        phase_q <= PH_IDLE;
      end
    end
  end

  assign phase_o    = phase_q;
  assign pair_sel_o = sel_q;
  assign evt_o      = start_w || (end_w && en_i);
endmodule

// File: rtl/irtx_regs.sv
module irtx_regs
  import irtx_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  parameter int unsigned CAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  input  logic              dma_ack_i,
  output ctrl_t             ctrl_o,
  output logic [PER_W-1:0]  mark_o,
  output logic [PER_W-1:0]  space_o,
  output logic [CAR_W-1:0]  car_hi_o [2],
  output logic [CAR_W-1:0]  car_lo_o [2],
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HB_W = PER_W - DATA_W;

  ctrl_t             ctrl_q;
  logic [HB_W-1:0]   mark_hi_q, space_hi_q;
  logic [DATA_W-1:0] mark_lo_q, space_lo_q;
  logic [CAR_W-1:0]  car_hi_q [2];
  logic [CAR_W-1:0]  car_lo_q [2];
  logic              flag_q, arm_q;
  logic              hi_wr_w;

  assign hi_wr_w = wr_en_i && (addr_i == A_MARK_HI || addr_i == A_SPACE_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      mark_hi_q  <= '0;
      mark_lo_q  <= '0;
      space_hi_q <= '0;
      space_lo_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CTRL:     ctrl_q     <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
        A_MARK_HI:  mark_hi_q  <= HB_W'(wdata_i);
        A_MARK_LO:  mark_lo_q  <= wdata_i;
        A_SPACE_HI: space_hi_q <= HB_W'(wdata_i);
        A_SPACE_LO: space_lo_q <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_pair
    localparam logic [ADDR_W-1:0] HA = (g == 0) ? A_CAR0_HI : A_CAR1_HI;
    localparam logic [ADDR_W-1:0] LA = (g == 0) ? A_CAR0_LO : A_CAR1_LO;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        car_hi_q[g] <= '0;
        car_lo_q[g] <= '0;
      end else if (wr_en_i) begin
        if (addr_i == HA) car_hi_q[g] <= CAR_W'(wdata_i);
        if (addr_i == LA) car_lo_q[g] <= CAR_W'(wdata_i);
      end
    end
  end

  // flag: setting wins; clearing needs a status read first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (evt_i)                              flag_q <= 1'b1;
      else if (dma_ack_i || (arm_q && hi_wr_w)) flag_q <= 1'b0;
      if (rd_en_i && addr_i == A_CTRL) arm_q <= 1'b1;
      else if (hi_wr_w)                arm_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:     rdata_o = {flag_q, ctrl_q};
      A_MARK_HI:  rdata_o = DATA_W'(mark_hi_q);
      A_MARK_LO:  rdata_o = mark_lo_q;
      A_SPACE_HI: rdata_o = DATA_W'(space_hi_q);
      A_SPACE_LO: rdata_o = space_lo_q;
      A_CAR0_HI:  rdata_o = DATA_W'(car_hi_q[0]);
      A_CAR0_LO:  rdata_o = DATA_W'(car_lo_q[0]);
      A_CAR1_HI:  rdata_o = DATA_W'(car_hi_q[1]);
      A_CAR1_LO:  rdata_o = DATA_W'(car_lo_q[1]);
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign mark_o   = {mark_hi_q, mark_lo_q};
  assign space_o  = {space_hi_q, space_lo_q};
  assign car_hi_o = car_hi_q;
  assign car_lo_o = car_lo_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/irtx_modulator.sv
module irtx_modulator
  import irtx_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  parameter int unsigned CAR_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dma_ack_i,
  output logic              mod_o,
  output logic              irq_o
);
  ctrl_t            ctrl_w;
  logic [PER_W-1:0] mark_w, space_w;
  logic [CAR_W-1:0] car_hi_w [2];
  logic [CAR_W-1:0] car_lo_w [2];
  logic             flag_q;
  logic             evt_w, tick_w, sel_w, lvl_w;
  phase_e           phase_w;

  irtx_regs #(.PER_W(PER_W), .CAR_W(CAR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .evt_i(evt_w), .dma_ack_i,
    .ctrl_o(ctrl_w), .mark_o(mark_w), .space_o(space_w),
    .car_hi_o(car_hi_w), .car_lo_o(car_lo_w),
    .flag_o(flag_q), .rdata_o
  );

  irtx_prescaler #(.SEL_W(SEL_W)) i_psc (
    .clk_i, .rst_ni, .sel_i(SEL_W'(ctrl_w.presc)), .tick_o(tick_w)
  );

  irtx_sequencer #(.PER_W(PER_W)) i_seq (
    .clk_i, .rst_ni, .tick_i(tick_w),
    .en_i(ctrl_w.en), .ext_i(ctrl_w.ext_space), .fsk_i(ctrl_w.fsk),
    .mark_buf_i(mark_w), .space_buf_i(space_w),
    .phase_o(phase_w), .pair_sel_o(sel_w), .evt_o(evt_w)
  );

  irtx_carrier #(.CAR_W(CAR_W)) i_car (
    .clk_i, .rst_ni, .tick_i(tick_w),
    .run_i(phase_w == PH_MARK && !ctrl_w.baseband),
    .high_i(car_hi_w[sel_w]), .low_i(car_lo_w[sel_w]),
    .lvl_o(lvl_w)
  );

  assign mod_o = (phase_w == PH_MARK) && (ctrl_w.baseband || lvl_w);
  assign irq_o = flag_q && ctrl_w.irq_en;
endmodule

// File: rtl/irtx_modulator_chk.sv
module irtx_modulator_chk
  import irtx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mod_o,
  input logic              irq_o,
  input logic              flag_i,
  input phase_e            phase_i,
  input logic              baseband_i,
  input logic              evt_i,
  input logic              dma_ack_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i
);
  p_base_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_MARK && baseband_i) |-> mod_o);

  p_space_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_SPACE) |-> !mod_o);

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_i);

  p_flag_clear_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(dma_ack_i ||
      (wr_en_i && (addr_i == A_MARK_HI || addr_i == A_SPACE_HI))));

  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_i);

  p_idle_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE) |-> !mod_o);
endmodule

bind irtx_modulator irtx_modulator_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mod_o(mod_o), .irq_o(irq_o),
  .flag_i(flag_q), .phase_i(phase_w), .baseband_i(ctrl_w.baseband),
  .evt_i(evt_w), .dma_ack_i(dma_ack_i), .wr_en_i(wr_en_i), .addr_i(addr_i)
);

// File: tb/test_irtx_modulator.sv
module test_irtx_modulator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, dma_ack = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       mod, irq;

  int checks = 0, errors = 0;
  logic cur = 1'b0, prev = 1'b0, rose = 1'b0, fell = 1'b0;
  int run = 0, last_hi = 0, last_lo = 0;

  // columns: prescale, mark, space, expected high clocks, expected low clocks
  localparam int VEC [5][5] = '{
    '{0, 5, 3, 5, 3},
    '{1, 4, 6, 8, 12},
    '{2, 3, 2, 12, 8},
    '{3, 2, 5, 16, 40},
    '{0, 0, 2, 1, 2}
  };

  always #4 clk = ~clk;

  irtx_modulator i_irtx_modulator (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .dma_ack_i(dma_ack),
    .mod_o(mod), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk);
    cur  = mod;
    rose = cur && !prev;
    fell = !cur && prev;
    if (rose || fell) begin
      if (fell) last_hi = run; else last_lo = run;
      run = 1;
    end else run++;
    prev = cur;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    sample();
    wr_en = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] d);
    rd_en = 1'b1; addr = 4'd0;
    #1 d = rdata;
    sample();
    rd_en = 1'b0;
  endtask

  task automatic cfg(input int m, input int s);
    wr(4'd1, 8'(m >> 8)); wr(4'd2, 8'(m));
    wr(4'd3, 8'(s >> 8)); wr(4'd4, 8'(s));
  endtask

  // ctrl byte: presc[6:5] ie[4] ext[3] fsk[2] base[1] en[0]
  function automatic logic [7:0] cb(int p, bit ie, bit ext, bit fsk, bit base, bit en);
    return {1'b0, 2'(p), ie, ext, fsk, base, en};
  endfunction

  task automatic wait_rise(); do sample(); while (!rose); endtask
  task automatic wait_fall(); do sample(); while (!fell); endtask
  task automatic idle_wait(); repeat (500) sample(); endtask

  task automatic burst(output int r, output int o);
    int lowrun = 0;
    wait_rise();
    r = 1; o = 1;
    while (lowrun < 8) begin
      sample();
      if (cur) begin o++; lowrun = 0; if (rose) r++; end
      else lowrun++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] st;
    int r1, o1, r2, o2, r3, o3, ones;
    repeat (3) sample();
    rst_n = 1'b1;
    sample();
    rd_status(st);
    chk(mod == 1'b0, "R13 mod after reset", int'(mod), 0);
    chk(irq == 1'b0, "R13 irq after reset", int'(irq), 0);
    chk(st == 8'h00, "R13 status after reset", int'(st), 0);

    // table walk: baseband pulse lengths per prescale (R1, R2)
    for (int i = 0; i < 5; i++) begin
      wr(4'd0, cb(VEC[i][0], 0, 0, 0, 1, 0));
      idle_wait();
      cfg(VEC[i][1], VEC[i][2]);
      wr(4'd0, cb(VEC[i][0], 0, 0, 0, 1, 1));
      wait_rise(); wait_fall(); wait_rise(); wait_fall();
      chk(last_hi == VEC[i][3], "R1 R2 mark length", last_hi, VEC[i][3]);
      wait_rise();
      chk(last_lo == VEC[i][4], "R1 R2 space length", last_lo, VEC[i][4]);
    end
    wr(4'd0, cb(0, 0, 0, 0, 1, 0));
    idle_wait();

    // R6 start, R10 irq, R8 clear sequence
    cfg(200, 200);
    wr(4'd0, cb(0, 1, 0, 0, 1, 1));
    chk(mod == 1'b0, "R6 not yet started", int'(mod), 0);
    sample();
    chk(mod == 1'b1, "R6 mark starts", int'(mod), 1);
    chk(irq == 1'b1, "R6 R10 flag and irq at start", int'(irq), 1);
    wr(4'd1, 8'd0);
    chk(irq == 1'b1, "R8 write without read keeps flag", int'(irq), 1);
    rd_status(st);
    chk(st[7] == 1'b1, "R6 status flag bit", int'(st[7]), 1);
    wr(4'd1, 8'd0);
    chk(irq == 1'b0, "R8 read then write clears", int'(irq), 0);
    begin
      int n = 0;
      while (!irq && n < 500) begin sample(); n++; end
      chk(irq == 1'b1, "R7 flag at cycle end", int'(irq), 1);
    end
    dma_ack = 1'b1; sample(); dma_ack = 1'b0;
    chk(irq == 1'b0, "R9 dma ack clears", int'(irq), 0);
    wr(4'd0, cb(0, 0, 0, 0, 1, 1));
    repeat (450) sample();
    rd_status(st);
    chk(st[7] == 1'b1 && irq == 1'b0, "R10 irq masked with flag set", int'(irq), 0);

    // R12 disable mid mark
    wait_rise(); repeat (5) sample();
    wr(4'd0, cb(0, 0, 0, 0, 1, 0));
    chk(mod == 1'b1, "R12 current mark continues", int'(mod), 1);
    idle_wait();
    ones = 0;
    repeat (100) begin sample(); if (cur) ones++; end
    chk(ones == 0, "R12 idle output low", ones, 0);

    // R5 buffer write affects next cycle only
    cfg(40, 40);
    wr(4'd0, cb(0, 0, 0, 0, 1, 1));
    wait_rise(); repeat (5) sample();
    wr(4'd2, 8'd10);
    wait_fall();
    chk(last_hi == 40, "R5 current mark unchanged", last_hi, 40);
    wait_rise(); wait_fall();
    chk(last_hi == 10, "R5 next mark uses new value", last_hi, 10);

    // R11 extended space
    wr(4'd0, cb(0, 0, 1, 0, 1, 1));
    repeat (100) sample();
    ones = 0;
    repeat (100) begin sample(); if (cur) ones++; end
    chk(ones == 0, "R11 extended space holds low", ones, 0);
    wr(4'd0, cb(0, 0, 0, 0, 1, 1));
    ones = 0;
    repeat (100) begin sample(); if (cur) ones++; end
    chk(ones > 0, "R11 marks resume", ones, 1);
    wr(4'd0, cb(0, 0, 0, 0, 0, 0));
    idle_wait();

    // R3 carrier: high 2, low 3, mark 10
    wr(4'd5, 8'd2); wr(4'd6, 8'd3);
    cfg(10, 20);
    wr(4'd0, cb(0, 0, 0, 0, 0, 1));
    burst(r1, o1);
    burst(r1, o1);
    chk(r1 == 2, "R3 carrier edges per mark", r1, 2);
    chk(o1 == 4, "R3 carrier high clocks per mark", o1, 4);
    wr(4'd0, cb(0, 0, 0, 0, 0, 0));
    idle_wait();

    // R4 FSK: primary 1/1, secondary 3/3, mark 12
    wr(4'd5, 8'd1); wr(4'd6, 8'd1); wr(4'd7, 8'd3); wr(4'd8, 8'd3);
    cfg(12, 20);
    wr(4'd0, cb(0, 0, 0, 1, 0, 1));
    burst(r1, o1); burst(r2, o2); burst(r3, o3);
    chk(r1 == 6, "R4 first mark primary pair", r1, 6);
    chk(r2 == 2, "R4 second mark secondary pair", r2, 2);
    chk(r3 == 6, "R4 third mark primary again", r3, 6);
    chk(o2 == 6, "R4 secondary high clocks", o2, 6);
    wr(4'd0, cb(0, 0, 0, 0, 0, 0));
    idle_wait();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule